// File: doc/BRIEF.md
# Receive Destination Address Filter with Address Table

This block sits at the front of an Ethernet receive path. It decides whether an incoming frame is kept by looking at its six-byte destination address, and it classifies each kept frame as individual, multicast or broadcast so the class code can go into the receive status word. The address bytes arrive one per clock, first byte first. One clock after the sixth byte, the block gives a one-cycle verdict. A frame that stops before the sixth byte gets a reject verdict instead.

Matching against specific stations uses a table of 16 48-bit addresses with a 16-bit enable mask. A load sequencer fills the table from memory. It walks a list of four-word records and then reads one more word, which becomes the enable mask. While the controller is held in reset mode, the host can read any entry back through three 16-bit ports, with the entry chosen by a pointer.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset there is no verdict, the sequencer is idle, every table entry reads back as zero and the enable mask is zero, so with all modes off no address is accepted.
- R2: With promiscuous mode on, a frame whose first destination byte has bit 0 clear is accepted with class 0x0000. Promiscuous mode alone does not accept a frame whose first byte has bit 0 set.
- R3: If R2 does not apply and accept-all-multicast is on, a frame whose first byte has bit 0 set is accepted with class 0x0100. This includes the all-ones address when broadcast is also enabled.
- R4: If R2 and R3 do not apply and broadcast is enabled, the all-ones address is accepted with class 0x0080. With broadcast disabled and no table match, the all-ones address is rejected.
- R5: If none of R2 to R4 apply, a frame is accepted with class 0x0000 when it equals a table entry whose enable bit is set. It is rejected otherwise, and a matching entry whose enable bit is clear does not count. A rejected verdict carries class 0x0000.
- R6: `decision_valid` is high for exactly the one cycle after the clock edge that takes the sixth address byte. Bytes that arrive after the sixth byte and before the next `rx_first` are ignored.
- R7: If `rx_end` arrives after one to five address bytes, the next cycle gives a verdict with `accept` low.
- R8: A load uses the low five bits of `load_count` as the number of entries. It reads four consecutive words per entry, starting at `load_base`, and advances by four words per entry. Word 1 holds address bytes 0 (bits 7:0) and 1 (bits 15:8), word 2 holds bytes 2 and 3, and word 3 holds bytes 4 and 5. Word 0 is not used. Entries are written from index 0 upward, and each entry is written whole in the cycle its third address word is read.
- R9: After the last entry (or at once if the count is zero), one more word is read and becomes the enable mask, where bit i enables entry i. The sequencer then goes idle and pulses `load_done` for one cycle. Entries not covered by the count keep their contents.
- R10: With `reset_mode` high, `rb_word0`, `rb_word1` and `rb_word2` return bytes 0/1, 2/3 and 4/5 of the entry selected by `rb_sel`, the lower-numbered byte in bits 7:0.
- R11: With `reset_mode` low, all three readback ports read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reset_mode | input | 1 | Controller is in reset mode; enables table readback |
| mode_promisc | input | 1 | Accept all individual-address frames |
| mode_all_mcast | input | 1 | Accept all group-address frames |
| mode_bcast | input | 1 | Accept the all-ones address |
| rx_valid | input | 1 | An address byte is present on rx_data |
| rx_first | input | 1 | This byte is the first destination byte of a frame |
| rx_end | input | 1 | The frame ends in this cycle |
| rx_data | input | 8 | Destination address byte |
| decision_valid | output | 1 | One-cycle verdict strobe |
| accept | output | 1 | Frame is accepted |
| frame_class | output | 16 | Class code: 0x0000, 0x0100 multicast, 0x0080 broadcast |
| load_go | input | 1 | Start a table load (ignored while busy) |
| load_base | input | AW | Word address of the first record |
| load_count | input | 5 | Number of entries to load |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | One-cycle pulse when the enable mask has been taken |
| mem_rd_en | output | 1 | Memory word read request |
| mem_rd_addr | output | AW | Word address being read |
| mem_rd_data | input | 16 | Read data, valid in the same cycle as the request |
| rb_sel | input | IDX_W | Entry selected for readback |
| rb_word0 | output | 16 | Entry bytes 0 and 1 |
| rb_word1 | output | 16 | Entry bytes 2 and 3 |
| rb_word2 | output | 16 | Entry bytes 4 and 5 |

## Verification
The assertions assume that `mem_rd_data` answers the address presented in the same cycle, and that a new `load_go` is not issued while `load_busy` is high. The bench meets both assumptions with a continuously assigned word array and by waiting for `load_done` before the next load. The verdict checks assume address bytes are framed by `rx_first`. The bench always opens a frame with `rx_first`, sends stray bytes only after a completed address, and drives every input at the falling edge.

// File: rtl/dest_filt_pkg.sv
package dest_filt_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned ADDR_W     = 8 * ADDR_BYTES;
  localparam logic [15:0] CLS_NONE   = 16'h0000;
  localparam logic [15:0] CLS_MCAST  = 16'h0100;
  localparam logic [15:0] CLS_BCAST  = 16'h0080;

  typedef struct packed {
    logic        accept;
    logic [15:0] cls;
  } verdict_t;

  // Fixed priority: promiscuous individual, all multicast, broadcast, table.
  function automatic verdict_t judge(input logic [ADDR_W-1:0] dst,
                                     input logic promisc,
                                     input logic all_mcast,
                                     input logic bcast_en,
                                     input logic table_hit);
    verdict_t v;
    v = '{accept: 1'b0, cls: CLS_NONE};
    if (promisc && !dst[0]) begin
      v.accept = 1'b1;
    end else if (all_mcast && dst[0]) begin
      v.accept = 1'b1;
      v.cls    = CLS_MCAST;
    end else if (bcast_en && (&dst)) begin
      v.accept = 1'b1;
      v.cls    = CLS_BCAST;
    end else if (table_hit) begin
      v.accept = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/addr_collector.sv
module addr_collector
  import dest_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_first,
  input  logic              rx_end,
  input  logic [7:0]        rx_data,
  output logic [ADDR_W-1:0] dst_next,
  output logic              addr_done,
  output logic              addr_short
);
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  pos;
  logic [CNT_W-1:0]  cnt_after;
  logic [ADDR_W-1:0] dst_q;
  logic              take;

  assign take      = rx_valid && (rx_first || cnt_q != '0);
  assign pos       = rx_first ? '0 : cnt_q;
  assign cnt_after = take ? pos + CNT_W'(1) : cnt_q;
  assign addr_done = take && (pos == CNT_W'(ADDR_BYTES - 1));
  assign addr_short = rx_end && !addr_done && (cnt_after != '0);

  always_comb begin
    dst_next = dst_q;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (take && pos == CNT_W'(i)) dst_next[8*i +: 8] = rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dst_q <= '0;
    end else begin
      cnt_q <= (addr_done || addr_short) ? '0 : cnt_after;
      dst_q <= dst_next;
    end
  end
endmodule

// File: rtl/cam_table.sv
module cam_table
  import dest_filt_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_entry,
  input  logic              mask_we,
  input  logic [ENTRIES-1:0] mask_word,
  input  logic [ADDR_W-1:0] probe,
  output logic              hit,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_entry
);
  logic [ENTRIES-1:0] en_q;
  logic [ENTRIES-1:0] hits;
  logic [ADDR_W-1:0]  ent_view [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (mask_we) en_q <= mask_word;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [ADDR_W-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  val <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))       val <= wr_entry;
    end
    assign hits[g]     = en_q[g] && (val == probe);
    assign ent_view[g] = val;
  end

  assign hit      = |hits;
  assign rd_entry = ent_view[rd_idx];
endmodule

// File: rtl/cam_loader.sv
module cam_loader
  import dest_filt_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int AW      = 16,
  parameter int CW      = 5,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [AW-1:0]     base_ptr,
  input  logic [CW-1:0]     count,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [15:0]       mem_rd_data,
  output logic              entry_commit,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [ADDR_W-1:0] wr_entry,
  output logic              mask_commit,
  output logic [15:0]       mask_word,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {LD_IDLE, LD_ENTRY, LD_MASK} ld_state_t;

  ld_state_t        st;
  logic [AW-1:0]    ptr;
  logic [CW-1:0]    left;
  logic [1:0]       widx;
  logic [IDX_W-1:0] eidx;
  logic [15:0]      w1_q, w2_q;

  assign busy         = (st != LD_IDLE);
  assign mem_rd_en    = busy;
  assign mem_rd_addr  = ptr + AW'(widx);
  assign entry_commit = (st == LD_ENTRY) && (widx == 2'd3);
  assign wr_idx       = eidx;
  assign wr_entry     = {mem_rd_data, w2_q, w1_q};
  assign mask_commit  = (st == LD_MASK);
  assign mask_word    = mem_rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= LD_IDLE;
      ptr  <= '0;
      left <= '0;
      widx <= '0;
      eidx <= '0;
      w1_q <= '0;
      w2_q <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        LD_IDLE: begin
          if (go) begin
            ptr  <= base_ptr;
            left <= count;
            widx <= '0;
            eidx <= '0;
            st   <= (count != '0) ? LD_ENTRY : LD_MASK;
          end
        end
        LD_ENTRY: begin
          if (widx == 2'd1) w1_q <= mem_rd_data;
          if (widx == 2'd2) w2_q <= mem_rd_data;
          if (widx == 2'd3) begin
            widx <= '0;
            ptr  <= ptr + AW'(4);
            eidx <= eidx + IDX_W'(1);
            left <= left - CW'(1);
            if (left == CW'(1)) st <= LD_MASK;
          end else begin
            widx <= widx + 2'd1;
          end
        end
        LD_MASK: begin
          st   <= LD_IDLE;
          done <= 1'b1;
        end
        default: st <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import dest_filt_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int AW      = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reset_mode,
  input  logic             mode_promisc,
  input  logic             mode_all_mcast,
  input  logic             mode_bcast,
  input  logic             rx_valid,
  input  logic             rx_first,
  input  logic             rx_end,
  input  logic [7:0]       rx_data,
  output logic             decision_valid,
  output logic             accept,
  output logic [15:0]      frame_class,
  input  logic             load_go,
  input  logic [AW-1:0]    load_base,
  input  logic [4:0]       load_count,
  output logic             load_busy,
  output logic             load_done,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic [15:0]      mem_rd_data,
  input  logic [IDX_W-1:0] rb_sel,
  output logic [15:0]      rb_word0,
  output logic [15:0]      rb_word1,
  output logic [15:0]      rb_word2
);
  logic [ADDR_W-1:0] dst_next;
  logic              addr_done, addr_short;
  logic              table_hit;
  logic              entry_commit, mask_commit;
  logic [IDX_W-1:0]  wr_idx;
  logic [ADDR_W-1:0] wr_entry;
  logic [15:0]       mask_word;
  logic [ADDR_W-1:0] rd_entry;
  verdict_t          verdict;

  addr_collector u_coll (
    .clk, .rst_n, .rx_valid, .rx_first, .rx_end, .rx_data,
    .dst_next, .addr_done, .addr_short
  );

  cam_loader #(.ENTRIES(ENTRIES), .AW(AW), .CW(5)) u_load (
    .clk, .rst_n, .go(load_go), .base_ptr(load_base), .count(load_count),
    .mem_rd_en, .mem_rd_addr, .mem_rd_data,
    .entry_commit, .wr_idx, .wr_entry, .mask_commit, .mask_word,
    .busy(load_busy), .done(load_done)
  );

  cam_table #(.ENTRIES(ENTRIES)) u_tab (
    .clk, .rst_n, .wr_en(entry_commit), .wr_idx, .wr_entry,
    .mask_we(mask_commit), .mask_word(mask_word[ENTRIES-1:0]),
    .probe(dst_next), .hit(table_hit), .rd_idx(rb_sel), .rd_entry
  );

  assign verdict = judge(dst_next, mode_promisc, mode_all_mcast, mode_bcast, table_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decision_valid <= 1'b0;
      accept         <= 1'b0;
      frame_class    <= CLS_NONE;
    end else begin
      decision_valid <= addr_done || addr_short;
      accept         <= addr_done && verdict.accept;
      frame_class    <= addr_done ? verdict.cls : CLS_NONE;
    end
  end

  assign rb_word0 = reset_mode ? rd_entry[15:0]  : 16'h0000;
  assign rb_word1 = reset_mode ? rd_entry[31:16] : 16'h0000;
  assign rb_word2 = reset_mode ? rd_entry[47:32] : 16'h0000;
endmodule

// File: rtl/dest_addr_filter_chk.sv
module dest_addr_filter_chk #(
  parameter int AW = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reset_mode,
  input logic        rx_valid,
  input logic        rx_end,
  input logic        decision_valid,
  input logic        accept,
  input logic [15:0] frame_class,
  input logic        load_busy,
  input logic        load_done,
  input logic        mem_rd_en,
  input logic        entry_commit,
  input logic        mask_commit,
  input logic [15:0] rb_word0,
  input logic [15:0] rb_word1,
  input logic [15:0] rb_word2
);
  // R6
  verdict_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |-> $past(rx_valid || rx_end));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !decision_valid |-> (!accept && frame_class == 16'h0000));

  // R3
  class_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |-> (frame_class == 16'h0000 || frame_class == 16'h0100
                        || frame_class == 16'h0080));

  // R5
  reject_no_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> frame_class == 16'h0000);

  // R11
  rb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_mode |-> (rb_word0 == 16'h0 && rb_word1 == 16'h0 && rb_word2 == 16'h0));

  // R9
  done_after_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (!load_busy && $past(mask_commit)));

  // R8
  commit_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_commit |-> (mem_rd_en && !mask_commit));
endmodule

bind dest_addr_filter dest_addr_filter_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode),
  .rx_valid(rx_valid), .rx_end(rx_end),
  .decision_valid(decision_valid), .accept(accept), .frame_class(frame_class),
  .load_busy(load_busy), .load_done(load_done), .mem_rd_en(mem_rd_en),
  .entry_commit(entry_commit), .mask_commit(mask_commit),
  .rb_word0(rb_word0), .rb_word1(rb_word1), .rb_word2(rb_word2)
);

// File: tb/tb_dest_addr_filter.sv
module tb_dest_addr_filter;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_mode = 1'b1;
  logic        mode_promisc = 1'b0, mode_all_mcast = 1'b0, mode_bcast = 1'b0;
  logic        rx_valid = 1'b0, rx_first = 1'b0, rx_end = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        decision_valid, accept;
  logic [15:0] frame_class;
  logic        load_go = 1'b0;
  logic [15:0] load_base = 16'h0;
  logic [4:0]  load_count = 5'd0;
  logic        load_busy, load_done, mem_rd_en;
  logic [15:0] mem_rd_addr, mem_rd_data;
  logic [3:0]  rb_sel = 4'd0;
  logic [15:0] rb_word0, rb_word1, rb_word2;
  logic [15:0] bmem [0:127];

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_P/2) clk = ~clk;
  assign mem_rd_data = bmem[mem_rd_addr[6:0]];

  dest_addr_filter dut (
    .clk, .rst_n, .reset_mode, .mode_promisc, .mode_all_mcast, .mode_bcast,
    .rx_valid, .rx_first, .rx_end, .rx_data, .decision_valid, .accept, .frame_class,
    .load_go, .load_base, .load_count, .load_busy, .load_done,
    .mem_rd_en, .mem_rd_addr, .mem_rd_data, .rb_sel, .rb_word0, .rb_word1, .rb_word2
  );

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] entry_of(input int base, input int k);
    return {bmem[base + 4*k + 3], bmem[base + 4*k + 2], bmem[base + 4*k + 1]};
  endfunction

  task automatic frame_test(input string req, input logic [47:0] d,
                            input logic exp_acc, input logic [15:0] exp_cls);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_first = (k == 0); rx_data = d[8*k +: 8];
      if (k == 5) chk({req, " early strobe"}, decision_valid, 1'b0);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_first = 1'b0;
    chk({req, " valid"}, decision_valid, 1'b1);
    chk({req, " accept"}, accept, exp_acc);
    chk({req, " class"}, frame_class, exp_cls);
    @(negedge clk);
    chk({req, " pulse end"}, decision_valid, 1'b0);
  endtask

  task automatic load_table(input string req, input logic [15:0] base, input logic [4:0] cnt);
    bit seen = 0;
    @(negedge clk);
    load_go = 1'b1; load_base = base; load_count = cnt;
    @(negedge clk);
    load_go = 1'b0;
    for (int i = 0; i < 300 && !seen; i++) begin
      if (load_done) seen = 1;
      else @(negedge clk);
    end
    chk({req, " done seen"}, seen, 1'b1);
    chk({req, " idle at done"}, load_busy, 1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 no verdict", decision_valid, 1'b0);
    chk("R1 loader idle", load_busy, 1'b0);
    chk("R1 entry zero", {rb_word2, rb_word1, rb_word0}, 48'h0);
    frame_test("R1 zero addr, mask clear", 48'h0, 1'b0, 16'h0000);
  endtask

  task automatic t_load_and_readback();
    load_table("R8 R9 load3", 16'h0010, 5'd3);
    reset_mode = 1'b1;
    for (int k = 0; k < 3; k++) begin
      rb_sel = 4'(k);
      #1;
      chk("R10 word0", rb_word0, bmem[16 + 4*k + 1]);
      chk("R10 word1", rb_word1, bmem[16 + 4*k + 2]);
      chk("R10 word2", rb_word2, bmem[16 + 4*k + 3]);
    end
    rb_sel = 4'd3;
    #1 chk("R8 uncovered entry kept zero", {rb_word2, rb_word1, rb_word0}, 48'h0);
    rb_sel = 4'd1;
    reset_mode = 1'b0;
    #1 chk("R11 ports zero", {rb_word2, rb_word1, rb_word0}, 48'h0);
  endtask

  task automatic t_cam();
    frame_test("R5 enabled entry0", entry_of(16, 0), 1'b1, 16'h0000);
    frame_test("R5 disabled entry1", entry_of(16, 1), 1'b0, 16'h0000);
    frame_test("R5 enabled entry2", entry_of(16, 2), 1'b1, 16'h0000);
    frame_test("R5 no match", 48'h665544332210, 1'b0, 16'h0000);
  endtask

  task automatic t_modes();
    mode_promisc = 1'b1;
    frame_test("R2 promisc individual", 48'h665544332210, 1'b1, 16'h0000);
    frame_test("R2 promisc group rejected", 48'h665544332211, 1'b0, 16'h0000);
    mode_promisc = 1'b0; mode_all_mcast = 1'b1;
    frame_test("R3 all multicast", 48'h665544332201, 1'b1, 16'h0100);
    mode_bcast = 1'b1;
    frame_test("R3 bcast as multicast", 48'hFFFFFFFFFFFF, 1'b1, 16'h0100);
    mode_all_mcast = 1'b0;
    frame_test("R4 broadcast", 48'hFFFFFFFFFFFF, 1'b1, 16'h0080);
    mode_bcast = 1'b0;
    frame_test("R4 broadcast disabled", 48'hFFFFFFFFFFFF, 1'b0, 16'h0000);
  endtask

  task automatic t_framing();
    frame_test("R6 frame then tail", entry_of(16, 0), 1'b1, 16'h0000);
    for (int k = 0; k < 7; k++) begin
      rx_valid = 1'b1; rx_first = 1'b0; rx_data = 8'hFF;
      @(negedge clk);
      chk("R6 tail bytes ignored", decision_valid, 1'b0);
    end
    rx_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_first = (k == 0); rx_data = 8'h00;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_first = 1'b0; rx_end = 1'b1;
    @(negedge clk);
    rx_end = 1'b0;
    chk("R7 short verdict", decision_valid, 1'b1);
    chk("R7 short rejected", accept, 1'b0);
    @(negedge clk);
    chk("R7 pulse end", decision_valid, 1'b0);
  endtask

  task automatic t_mask_only();
    load_table("R9 count zero", 16'h0040, 5'd0);
    frame_test("R9 new mask enables entry1", entry_of(16, 1), 1'b1, 16'h0000);
    frame_test("R9 new mask disables entry0", entry_of(16, 0), 1'b0, 16'h0000);
    reset_mode = 1'b1; rb_sel = 4'd0;
    #1 chk("R9 entries kept", {rb_word2, rb_word1, rb_word0}, entry_of(16, 0));
  endtask

  task automatic run_all();
    t_reset();
    t_load_and_readback();
    t_cam();
    t_modes();
    t_framing();
    t_mask_only();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) bmem[i] = 16'hA5A5;
    for (int k = 0; k < 3; k++) begin
      bmem[16 + 4*k]     = 16'hDEAD;
      bmem[16 + 4*k + 1] = 16'h3400 + 16'(2*k);
      bmem[16 + 4*k + 2] = 16'h5600 + 16'(k);
      bmem[16 + 4*k + 3] = 16'h7800 + 16'(k);
    end
    bmem[28] = 16'h0005;
    bmem[64] = 16'h0002;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule